// File: doc/BRIEF.md
# Debug Run/Stop Controller

This block decides, while a program is being debugged, whether the core may keep executing or must be held. Four kinds of event can stop execution: the core retiring a software breakpoint instruction, the fetch address equalling one of several programmable code breakpoints, a data-space access that matches a masked address and access-type filter, and a stop command arriving from the debug port. They are honoured only while the debug-enable input is high. A run command from the debug port releases the core.

The controller is a three-state machine: RUNNING (`ST_RUN`), HALTED (`ST_HALT`), and RESUMING (`ST_RESUME`). RESUMING is a running state entered after a run command, in which code-breakpoint hits are masked until the first fetch completes, so execution can restart from the breakpoint address. Transitions: RUN→HALT on any enabled stop request; RESUME→HALT on any stop request other than a code hit; RESUME→RUN on the first fetch without a stop; HALT→RESUME on a run command; any state→RUN when debug-enable is low. On entry to HALTED a 3-bit cause code records the winning request and is held until the state leaves HALTED, which clears it to zero.

Breakpoint registers are loaded through a small write port: a slot select, an address word and a 2-bit control field.

Top module: `dbg_runstop`

## Requirements
- R1: After reset the block is RUNNING with `halt`=0 and `stop_cause`=0, every code breakpoint is disabled and the data filter selects no access type, so no fetch or access can stop it.
- R2: While `dbg_en` is low no request stops execution, and lowering `dbg_en` while HALTED returns the block to RUNNING with `stop_cause`=0 on the next cycle.
- R3: `cmd_stop` sampled high while running (with `dbg_en` high) gives `halt`=1 and `stop_cause`=1 one cycle later.
- R4: `brk_exec` sampled high while running gives `halt`=1 and `stop_cause`=2 one cycle later, unless a higher-priority request is present.
- R5: A cycle with `fetch_valid` high and `pc` equal to the address of an enabled code breakpoint gives `halt`=1 and `stop_cause`=3 one cycle later; a disabled slot, or `fetch_valid` low, never matches.
- R6: A cycle with `da_valid` high matches the data breakpoint when `(da_addr & mask) == (bp_addr & mask)` and the access type is selected: control 0 = none, 1 = reads (`da_write`=0), 2 = writes (`da_write`=1), 3 = both. A match gives `halt`=1 and `stop_cause`=4 one cycle later.
- R7: When several requests arrive in the same cycle the recorded cause is the highest in the order stop command (1), breakpoint instruction (2), code match (3), data match (4).
- R8: While HALTED with `dbg_en` high and no run command, `halt` stays 1 and `stop_cause` keeps its value whatever stop requests arrive.
- R9: `cmd_run` while HALTED gives `halt`=0 and `stop_cause`=0 one cycle later, and wins over a simultaneous `cmd_stop`; `cmd_run` while running has no effect.
- R10: After a run command, code-breakpoint matches are ignored until the first cycle with `fetch_valid` high has passed (that cycle included); cycles without a fetch do not consume the mask, and the other three requests still stop execution meanwhile.
- R11: A write with `cfg_we` high loads slot `cfg_sel`: slots 0..3 set code breakpoint address (`cfg_addr`) and enable (`cfg_ctl[0]`), slot 4 sets the data breakpoint address and access select (`cfg_ctl`), slot 5 sets the data mask; a rewrite replaces the earlier value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dbg_en | input | 1 | Debug mode enabled |
| brk_exec | input | 1 | Software breakpoint instruction executed |
| fetch_valid | input | 1 | A fetch at `pc` takes place this cycle |
| pc | input | AW | Current fetch address |
| da_valid | input | 1 | Data-space access this cycle |
| da_write | input | 1 | Access is a write (0 = read) |
| da_addr | input | AW | Data-space access address |
| cmd_run | input | 1 | Run command from the debug port |
| cmd_stop | input | 1 | Stop command from the debug port |
| cfg_we | input | 1 | Breakpoint register write strobe |
| cfg_sel | input | SEL_W | Breakpoint slot select |
| cfg_addr | input | AW | Address or mask word to write |
| cfg_ctl | input | 2 | Enable bit (code slots) or access select (data slot) |
| halt | output | 1 | Core held: state is HALTED |
| stop_cause | output | 3 | Recorded stop cause, 0 when not halted |

## Verification
Every result of this block is due exactly one clock edge after the input cycle that causes it: requests, commands and enable changes are all sampled at one edge and appear on `halt` and `stop_cause` straight after it, while a configuration write becomes effective for the cycle following its edge. The bench drives each stimulus for one cycle just after a rising edge, advances one edge, and samples outputs two nanoseconds later, so each check observes the state produced by exactly that stimulus. Before each stop test the bench runs one non-matching fetch so the machine is in plain RUNNING rather than RESUMING, and it releases every halt with a run command so the next case starts from a known state.

// File: rtl/dbg_runstop_pkg.sv
package dbg_runstop_pkg;

    typedef enum logic [2:0] {
        CAUSE_NONE = 3'd0,
        CAUSE_CMD  = 3'd1,
        CAUSE_BRK  = 3'd2,
        CAUSE_CODE = 3'd3,
        CAUSE_DATA = 3'd4
    } stop_cause_e;

    typedef enum logic [1:0] {
        ACC_OFF   = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_BOTH  = 2'd3
    } acc_sel_e;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_RESUME = 2'd1,
        ST_HALT   = 2'd2
    } run_state_e;

endpackage

// File: rtl/dbg_code_cmp.sv
module dbg_code_cmp #(
    parameter int AW     = 16,
    parameter int NUM_BP = 4,
    parameter int SEL_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [AW-1:0]    cfg_addr,
    input  logic             cfg_enable,
    input  logic             fetch_valid,
    input  logic [AW-1:0]    pc,
    output logic             code_hit
);

    logic [NUM_BP-1:0] hit_vec;

    for (genvar g = 0; g < NUM_BP; g++) begin : g_slot
        logic [AW-1:0] bp_addr_q;
        logic          bp_en_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bp_addr_q <= '0;
                bp_en_q   <= 1'b0;
            end else if (cfg_we && (cfg_sel == SEL_W'(g))) begin
                bp_addr_q <= cfg_addr;
                bp_en_q   <= cfg_enable;
            end
        end

        assign hit_vec[g] = fetch_valid && bp_en_q && (pc == bp_addr_q);
    end

    assign code_hit = |hit_vec;

endmodule

// File: rtl/dbg_data_cmp.sv
module dbg_data_cmp
    import dbg_runstop_pkg::*;
#(
    parameter int AW        = 16,
    parameter int SEL_W     = 3,
    parameter int ADDR_SLOT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [AW-1:0]    cfg_addr,
    input  logic [1:0]       cfg_ctl,
    input  logic             da_valid,
    input  logic             da_write,
    input  logic [AW-1:0]    da_addr,
    output logic             data_hit
);

    localparam int MASK_SLOT = ADDR_SLOT + 1;

    logic [AW-1:0] addr_q;
    logic [AW-1:0] mask_q;
    acc_sel_e      sel_q;
    logic [1:0]    sel_bits;
    logic          type_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            mask_q <= '1;
            sel_q  <= ACC_OFF;
        end else if (cfg_we) begin
            if (cfg_sel == SEL_W'(ADDR_SLOT)) begin
                addr_q <= cfg_addr;
                sel_q  <= acc_sel_e'(cfg_ctl);
            end else if (cfg_sel == SEL_W'(MASK_SLOT)) begin
                mask_q <= cfg_addr;
            end
        end
    end

    assign sel_bits = sel_q;
    assign type_ok  = da_write ? sel_bits[1] : sel_bits[0];
    assign data_hit = da_valid && type_ok && (((da_addr ^ addr_q) & mask_q) == '0);

endmodule

// File: rtl/dbg_runstop_fsm.sv
module dbg_runstop_fsm
    import dbg_runstop_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        dbg_en,
    input  logic        cmd_run,
    input  logic        cmd_stop,
    input  logic        brk_exec,
    input  logic        fetch_valid,
    input  logic        code_hit,
    input  logic        data_hit,
    output logic        halt,
    output stop_cause_e cause
);

    run_state_e  state_q, state_d;
    stop_cause_e cause_q, cause_d;
    stop_cause_e req;
    logic        code_armed;

    assign code_armed = (state_q != ST_RESUME);

    always_comb begin
        if (cmd_stop)                     req = CAUSE_CMD;
        else if (brk_exec)                req = CAUSE_BRK;
        else if (code_hit && code_armed)  req = CAUSE_CODE;
        else if (data_hit)                req = CAUSE_DATA;
        else                              req = CAUSE_NONE;
    end

    always_comb begin
        state_d = state_q;
        cause_d = cause_q;
        unique case (state_q)
            ST_RUN, ST_RESUME: begin
                if (!dbg_en) begin
                    state_d = ST_RUN;
                    cause_d = CAUSE_NONE;
                end else if (req != CAUSE_NONE) begin
                    state_d = ST_HALT;
                    cause_d = req;
                end else if ((state_q == ST_RESUME) && fetch_valid) begin
                    state_d = ST_RUN;
                end
            end
            ST_HALT: begin
                if (!dbg_en) begin
                    state_d = ST_RUN;
                    cause_d = CAUSE_NONE;
                end else if (cmd_run) begin
                    state_d = ST_RESUME;
                    cause_d = CAUSE_NONE;
                end
            end
            default: begin
                state_d = ST_RUN;
                cause_d = CAUSE_NONE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            cause_q <= CAUSE_NONE;
        end else begin
            state_q <= state_d;
            cause_q <= cause_d;
        end
    end

    always_comb begin
        halt  = (state_q == ST_HALT);
        cause = cause_q;
    end

endmodule

// File: rtl/dbg_runstop.sv
module dbg_runstop
    import dbg_runstop_pkg::*;
#(
    parameter int  AW          = 16,
    parameter int  NUM_CODE_BP = 4,
    localparam int SEL_W       = $clog2(NUM_CODE_BP + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dbg_en,
    input  logic             brk_exec,
    input  logic             fetch_valid,
    input  logic [AW-1:0]    pc,
    input  logic             da_valid,
    input  logic             da_write,
    input  logic [AW-1:0]    da_addr,
    input  logic             cmd_run,
    input  logic             cmd_stop,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [AW-1:0]    cfg_addr,
    input  logic [1:0]       cfg_ctl,
    output logic             halt,
    output logic [2:0]       stop_cause
);

    logic        code_hit;
    logic        data_hit;
    stop_cause_e cause_w;

    dbg_code_cmp #(
        .AW     (AW),
        .NUM_BP (NUM_CODE_BP),
        .SEL_W  (SEL_W)
    ) u_code (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_sel     (cfg_sel),
        .cfg_addr    (cfg_addr),
        .cfg_enable  (cfg_ctl[0]),
        .fetch_valid (fetch_valid),
        .pc          (pc),
        .code_hit    (code_hit)
    );

    dbg_data_cmp #(
        .AW        (AW),
        .SEL_W     (SEL_W),
        .ADDR_SLOT (NUM_CODE_BP)
    ) u_data (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_sel  (cfg_sel),
        .cfg_addr (cfg_addr),
        .cfg_ctl  (cfg_ctl),
        .da_valid (da_valid),
        .da_write (da_write),
        .da_addr  (da_addr),
        .data_hit (data_hit)
    );

    dbg_runstop_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .dbg_en      (dbg_en),
        .cmd_run     (cmd_run),
        .cmd_stop    (cmd_stop),
        .brk_exec    (brk_exec),
        .fetch_valid (fetch_valid),
        .code_hit    (code_hit),
        .data_hit    (data_hit),
        .halt        (halt),
        .cause       (cause_w)
    );

    assign stop_cause = cause_w;

endmodule

// File: rtl/dbg_runstop_chk.sv
module dbg_runstop_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       dbg_en,
    input logic       brk_exec,
    input logic       cmd_run,
    input logic       cmd_stop,
    input logic       halt,
    input logic [2:0] stop_cause
);

    AST_EN_GATES_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        !dbg_en |=> !halt); // R2

    AST_CMD_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_en && !halt && cmd_stop) |=> (halt && stop_cause == 3'd1)); // R3

    AST_BRK_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_en && !halt && !cmd_stop && brk_exec) |=> (halt && stop_cause == 3'd2)); // R4

    AST_CAUSE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> (stop_cause != 3'd0 && stop_cause <= 3'd4)); // R7

    AST_HALT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_en && halt && !cmd_run) |=> (halt && $stable(stop_cause))); // R8

    AST_RUN_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_en && halt && cmd_run) |=> (!halt && stop_cause == 3'd0)); // R9

    AST_CAUSE_CLEAR_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        !halt |-> (stop_cause == 3'd0)); // R9

endmodule

bind dbg_runstop dbg_runstop_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dbg_en     (dbg_en),
    .brk_exec   (brk_exec),
    .cmd_run    (cmd_run),
    .cmd_stop   (cmd_stop),
    .halt       (halt),
    .stop_cause (stop_cause)
);

// File: tb/dbg_runstop_tb.sv
`timescale 1ns/1ps
module dbg_runstop_tb;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dbg_en = 1'b0, brk_exec = 1'b0, fetch_valid = 1'b0;
    logic          da_valid = 1'b0, da_write = 1'b0;
    logic          cmd_run = 1'b0, cmd_stop = 1'b0, cfg_we = 1'b0;
    logic [AW-1:0] pc = '0, da_addr = '0, cfg_addr = '0;
    logic [2:0]    cfg_sel = '0;
    logic [1:0]    cfg_ctl = '0;
    logic          halt;
    logic [2:0]    stop_cause;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dbg_runstop u_dut (
        .clk(clk), .rst_n(rst_n), .dbg_en(dbg_en), .brk_exec(brk_exec),
        .fetch_valid(fetch_valid), .pc(pc), .da_valid(da_valid),
        .da_write(da_write), .da_addr(da_addr), .cmd_run(cmd_run),
        .cmd_stop(cmd_stop), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_addr(cfg_addr), .cfg_ctl(cfg_ctl), .halt(halt),
        .stop_cause(stop_cause)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input logic eh, input logic [2:0] ec, input string req);
        checks++;
        if (halt !== eh || stop_cause !== ec) begin
            failures++;
            $display("FAIL %s: halt=%0b cause=%0d expected halt=%0b cause=%0d",
                     req, halt, stop_cause, eh, ec);
        end
    endtask

    task automatic cfg(input logic [2:0] sel, input logic [AW-1:0] a, input logic [1:0] c);
        cfg_we = 1'b1; cfg_sel = sel; cfg_addr = a; cfg_ctl = c;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic prime();
        fetch_valid = 1'b1; pc = 16'h0FF0;
        tick();
        fetch_valid = 1'b0;
    endtask

    task automatic resume();
        cmd_run = 1'b1;
        tick();
        cmd_run = 1'b0;
        check(1'b0, 3'd0, "R9");
        prime();
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check(1'b0, 3'd0, "R1");
        rst_n = 1'b1;
        tick();
        check(1'b0, 3'd0, "R1");

        // R1: reset configuration matches nothing
        dbg_en = 1'b1;
        fetch_valid = 1'b1; pc = '0; da_valid = 1'b1; da_addr = '0; da_write = 1'b1;
        tick();
        fetch_valid = 1'b0; da_valid = 1'b0; da_write = 1'b0;
        check(1'b0, 3'd0, "R1");
        da_valid = 1'b1;
        tick();
        da_valid = 1'b0;
        check(1'b0, 3'd0, "R1");

        // priority sweep, with and without debug enable (R2..R7)
        cfg(3'd0, 16'h0400, 2'd1);
        cfg(3'd4, 16'h2000, 2'd3);
        cfg(3'd5, 16'hFFFF, 2'd0);
        for (int en = 1; en >= 0; en--) begin
            for (int v = 0; v < 16; v++) begin
                logic [2:0] ec;
                int nsrc;
                string tag;
                dbg_en = 1'b1;
                prime();
                dbg_en = logic'(en);
                cmd_stop = v[3]; brk_exec = v[2];
                fetch_valid = 1'b1; pc = v[1] ? 16'h0400 : 16'h0FF0;
                da_valid = v[0]; da_addr = 16'h2000; da_write = 1'b0;
                tick();
                cmd_stop = 1'b0; brk_exec = 1'b0; fetch_valid = 1'b0; da_valid = 1'b0;
                nsrc = int'(v[3]) + int'(v[2]) + int'(v[1]) + int'(v[0]);
                if (en == 0)   ec = 3'd0;
                else if (v[3]) ec = 3'd1;
                else if (v[2]) ec = 3'd2;
                else if (v[1]) ec = 3'd3;
                else if (v[0]) ec = 3'd4;
                else           ec = 3'd0;
                if (en == 0)        tag = "R2";
                else if (nsrc > 1)  tag = "R7";
                else if (v[3])      tag = "R3";
                else if (v[2])      tag = "R4";
                else if (v[1])      tag = "R5";
                else                tag = "R6";
                check(ec != 3'd0, ec, tag);
                dbg_en = 1'b1;
                if (ec != 3'd0) resume();
            end
        end
        dbg_en = 1'b1;
        cfg(3'd4, 16'h2000, 2'd0);

        // code breakpoint slots and enables (R5, R11)
        for (int i = 0; i < 4; i++) begin
            for (int e = 0; e < 2; e++) begin
                logic [AW-1:0] a;
                a = 16'h1000 + AW'(i) * 16'h0011;
                cfg(3'(i), a, 2'(e));
                prime();
                fetch_valid = 1'b1; pc = a;
                tick();
                fetch_valid = 1'b0;
                check(logic'(e), (e == 1) ? 3'd3 : 3'd0, "R5");
                if (e == 1) resume();
            end
        end
        pc = 16'h1000;
        tick();
        check(1'b0, 3'd0, "R5");
        cfg(3'd1, 16'h1011, 2'd0);
        fetch_valid = 1'b1; pc = 16'h1011;
        tick();
        fetch_valid = 1'b0;
        check(1'b0, 3'd0, "R11");

        // data filter: select x direction x masked address (R6)
        cfg(3'd5, 16'hFF00, 2'd0);
        for (int s = 0; s < 4; s++) begin
            cfg(3'd4, 16'h12F0, 2'(s));
            for (int w = 0; w < 2; w++) begin
                for (int m = 0; m < 2; m++) begin
                    logic [1:0] sb;
                    logic exp_hit;
                    sb = 2'(s);
                    exp_hit = (m == 1) && ((w == 1) ? sb[1] : sb[0]);
                    prime();
                    da_valid = 1'b1; da_write = logic'(w);
                    da_addr = (m == 1) ? 16'h1234 : 16'h1334;
                    tick();
                    da_valid = 1'b0; da_write = 1'b0;
                    check(exp_hit, exp_hit ? 3'd4 : 3'd0, "R6");
                    if (exp_hit) resume();
                end
            end
        end

        // halted state holds against new requests (R3, R8)
        prime();
        cmd_stop = 1'b1;
        tick();
        cmd_stop = 1'b0;
        check(1'b1, 3'd1, "R3");
        for (int k = 0; k < 3; k++) begin
            brk_exec = 1'b1; cmd_stop = 1'b1;
            da_valid = 1'b1; da_addr = 16'h1234;
            fetch_valid = 1'b1; pc = 16'h1000;
            tick();
            brk_exec = 1'b0; cmd_stop = 1'b0; da_valid = 1'b0; fetch_valid = 1'b0;
            check(1'b1, 3'd1, "R8");
        end
        resume();

        // run commands (R9)
        cmd_run = 1'b1;
        tick();
        cmd_run = 1'b0;
        check(1'b0, 3'd0, "R9");
        cmd_stop = 1'b1;
        tick();
        cmd_stop = 1'b0;
        check(1'b1, 3'd1, "R3");
        cmd_run = 1'b1; cmd_stop = 1'b1;
        tick();
        cmd_run = 1'b0; cmd_stop = 1'b0;
        check(1'b0, 3'd0, "R9");
        prime();

        // resume masking of code matches (R10)
        cfg(3'd0, 16'h0400, 2'd1);
        fetch_valid = 1'b1; pc = 16'h0400;
        tick();
        fetch_valid = 1'b0;
        check(1'b1, 3'd3, "R5");
        cmd_run = 1'b1;
        tick();
        cmd_run = 1'b0;
        check(1'b0, 3'd0, "R9");
        tick();
        check(1'b0, 3'd0, "R10");
        fetch_valid = 1'b1;
        tick();
        check(1'b0, 3'd0, "R10");
        tick();
        fetch_valid = 1'b0;
        check(1'b1, 3'd3, "R10");
        cmd_run = 1'b1;
        tick();
        cmd_run = 1'b0;
        brk_exec = 1'b1;
        tick();
        brk_exec = 1'b0;
        check(1'b1, 3'd2, "R10");

        // dropping debug enable (R2)
        dbg_en = 1'b0;
        tick();
        check(1'b0, 3'd0, "R2");
        cmd_stop = 1'b1;
        tick();
        cmd_stop = 1'b0;
        check(1'b0, 3'd0, "R2");
        dbg_en = 1'b1;
        prime();
        check(1'b0, 3'd0, "R2");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule